// File: doc/BRIEF.md
# I2C Dual-Address Port Expander Slave

This block is an I2C slave that answers on two 7-bit addresses, one for each of its two 8-bit port groups. The first group is a set of push-pull outputs. The second is a set of open-drain I/Os, shown as per-pin pull-low enables, with a separate input bus that carries the pin levels. A write to a group's address stores each acknowledged data byte in that group's output latch straight away. A read returns a snapshot of the ports. The snapshot is taken during the address acknowledge and again at every master acknowledge, so each byte of a multi-byte read carries fresh data. For the push-pull group, the value read back is the output latch.

SCL and SDA are sampled with a fast system clock through two-flop synchronizers. START and STOP are found from SDA edges while SCL is high. SDA is driven only as a pull-low enable. An active-low interrupt flags any open-drain input that differs from the most recent snapshot. The interrupt stays low until the address acknowledge of a write to the open-drain group.

Top module: `i2c_dual_port_expander`

## Requirements
- R1: After reset, `pp_out` is 8'hFF, `od_oe` is 8'h00 (all open-drain pins released), `int_n` is 1 and `sda_oe` is 0.
- R2: The slave pulls SDA low during the acknowledge bit of an address byte whose upper 7 bits equal `PP_ADDR` or `OD_ADDR`. The LSB of the address byte is R/W, with 0 meaning write.
- R3: An address matching neither parameter is not acknowledged. Every later byte up to the next START is ignored: no acknowledge, and no latch change.
- R4: Each data byte written to `PP_ADDR` is acknowledged and appears on `pp_out` by the end of its acknowledge bit. A transaction may carry several such bytes.
- R5: Each data byte written to `OD_ADDR` is acknowledged and sets `od_oe` to its bitwise inverse (latch bit 0 pulls the pin low, bit 1 releases it).
- R6: In a read, the first byte is sent MSB first. For `OD_ADDR` it carries `od_in` as sampled during the address acknowledge. For `PP_ADDR` it carries the push-pull latch.
- R7: During a multi-byte read, the ports are resampled at each master ACK, and the next byte carries the new value.
- R8: After a master NACK, the slave keeps SDA released until STOP or START.
- R9: `int_n` goes low when the synchronized `od_in` differs from the most recent snapshot, and stays low after that.
- R10: `int_n` returns high only during the address acknowledge of a write to `OD_ADDR`. Writes to `PP_ADDR` and reads leave it low.
- R11: A repeated START, with or without a preceding STOP, restarts address reception from any state.
- R12: A STOP returns the slave to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| pp_out | output | 8 | Push-pull group outputs |
| od_oe | output | 8 | Open-drain group pull-low enables, 1 = pin driven low |
| od_in | input | 8 | Open-drain group pin levels |
| int_n | output | 1 | Active-low change interrupt |

## Verification
On every cycle, the assertions check the following:
- SDA changes only while the synchronized SCL is low, or on a START or STOP.
- Each output latch changes only from the write-data state of its own group.
- The interrupt falls only on a real snapshot mismatch, and rises only in an open-drain write address acknowledge.
- The slave never drives SDA while ignoring the bus, and a STOP always lands in idle.

Only the bench scenarios can show the values themselves: the acknowledge on the wire, the bytes sent in reads, fresh data at each master ACK across a three-byte read, the NACK release, and recovery after a repeated START.

// File: rtl/i2c_dual_port_expander.sv
module i2c_dual_port_expander #(
  parameter logic [6:0] PP_ADDR = 7'h6D,
  parameter logic [6:0] OD_ADDR = 7'h5C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] pp_out,
  output logic [7:0] od_oe,
  input  logic [7:0] od_in,
  output logic       int_n
);
  localparam logic [2:0] S_IDLE = 3'd0, S_ADDR = 3'd1, S_AACK = 3'd2, S_WDAT = 3'd3,
                         S_WACK = 3'd4, S_RDAT = 3'd5, S_RACK = 3'd6, S_IGN  = 3'd7;

  logic [2:0] scl_sy, sda_sy;
  logic [7:0] od_m, od_s;
  logic [2:0] st;
  logic [3:0] cnt;
  logic [7:0] sh, rdat, snap, pp_q, od_q;
  logic       irq, rw_q, grp_q, ackd;
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 3'b111;
      sda_sy <= 3'b111;
      od_m   <= 8'hFF;
      od_s   <= 8'hFF;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
      od_m   <= od_in;
      od_s   <= od_m;
    end

  assign scl_s     = scl_sy[1];
  assign sda_s     = sda_sy[1];
  assign scl_rise  = scl_s & ~scl_sy[2];
  assign scl_fall  = ~scl_s & scl_sy[2];
  assign start_det = scl_s & scl_sy[2] & ~sda_s & sda_sy[2];
  assign stop_det  = scl_s & scl_sy[2] & sda_s & ~sda_sy[2];

  assign pp_out = pp_q;
  assign od_oe  = ~od_q;
  assign int_n  = ~irq;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= 4'd0;
      sh     <= 8'h00;
      rdat   <= 8'hFF;
      snap   <= 8'hFF;
      irq    <= 1'b0;
      rw_q   <= 1'b0;
      grp_q  <= 1'b0;
      ackd   <= 1'b0;
      pp_q   <= 8'hFF;
      od_q   <= 8'hFF;
      sda_oe <= 1'b0;
    end else begin
      if (od_s != snap) irq <= 1'b1;
      if (start_det) begin
        st     <= S_ADDR;
        cnt    <= 4'd0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR:
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (sh[7:1] == PP_ADDR || sh[7:1] == OD_ADDR) begin
                sda_oe <= 1'b1;
                grp_q  <= (sh[7:1] == OD_ADDR);
                rw_q   <= sh[0];
                st     <= S_AACK;
              end else begin
                st <= S_IGN;
              end
            end
          S_AACK:
            if (scl_rise) begin
              snap <= od_s;
              rdat <= grp_q ? od_s : pp_q;
              if (!rw_q && grp_q) irq <= 1'b0;
            end else if (scl_fall) begin
              if (rw_q) begin
                sda_oe <= ~rdat[7];
                cnt    <= 4'd1;
                st     <= S_RDAT;
              end else begin
                sda_oe <= 1'b0;
                cnt    <= 4'd0;
                st     <= S_WDAT;
              end
            end
          S_WDAT:
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (grp_q) od_q <= sh;
              else       pp_q <= sh;
              sda_oe <= 1'b1;
              st     <= S_WACK;
            end
          S_WACK:
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= 4'd0;
              st     <= S_WDAT;
            end
          S_RDAT:
            if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= S_RACK;
              end else begin
                sda_oe <= ~rdat[3'd7 - cnt[2:0]];
                cnt    <= cnt + 4'd1;
              end
            end
          S_RACK:
            if (scl_rise) begin
              ackd <= ~sda_s;
              if (!sda_s) begin
                snap <= od_s;
                rdat <= grp_q ? od_s : pp_q;
              end
            end else if (scl_fall) begin
              if (ackd) begin
                sda_oe <= ~rdat[7];
                cnt    <= 4'd1;
                st     <= S_RDAT;
              end else begin
                st <= S_IGN;
              end
            end
          default: ;
        endcase
      end
    end
endmodule

// File: rtl/i2c_dual_port_expander_chk.sv
module i2c_dual_port_expander_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       start_det,
  input logic       stop_det,
  input logic       sda_oe,
  input logic       int_n,
  input logic [7:0] od_s,
  input logic [7:0] snap,
  input logic [2:0] st,
  input logic       rw_q,
  input logic       grp_q,
  input logic [7:0] pp_out,
  input logic [7:0] od_oe
);
  localparam logic [2:0] C_IDLE = 3'd0, C_AACK = 3'd2, C_WDAT = 3'd3, C_IGN = 3'd7;

  // R2
  sda_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)));

  // R3
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_IGN) |-> !sda_oe);

  // R4
  pp_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pp_out != $past(pp_out)) |-> ($past(st) == C_WDAT && !$past(grp_q)));

  // R5
  od_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (od_oe != $past(od_oe)) |-> ($past(st) == C_WDAT && $past(grp_q)));

  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> $past(od_s != snap));

  // R10
  irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_n) |-> ($past(st) == C_AACK && !$past(rw_q) && $past(grp_q)));

  // R12
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == C_IDLE && !sda_oe));
endmodule

bind i2c_dual_port_expander i2c_dual_port_expander_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det), .stop_det(stop_det),
  .sda_oe(sda_oe), .int_n(int_n), .od_s(od_s), .snap(snap), .st(st), .rw_q(rw_q),
  .grp_q(grp_q), .pp_out(pp_out), .od_oe(od_oe)
);

// File: tb/sim_i2c_dual_port_expander.sv
module sim_i2c_dual_port_expander;
  localparam logic [6:0] PPA = 7'h6D, ODA = 7'h5C;
  localparam int Q = 10;

  logic clk = 0, rst_n = 0, scl = 1, sda_m = 1;
  logic [7:0] od_in = 8'hFF;
  logic sda_oe, int_n;
  logic [7:0] pp_out, od_oe;
  wire sda_line = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  i2c_dual_port_expander #(.PP_ADDR(PPA), .OD_ADDR(ODA)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .pp_out(pp_out), .od_oe(od_oe), .od_in(od_in), .int_n(int_n));

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] rd_val;
  event rd_ev;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  initial forever begin
    @(rd_ev);
    if (exp_q.size() == 0) begin
      checks++; errors++;
      $display("FAIL scoreboard actual %h expected none", rd_val);
    end else chk(tag_q.pop_front(), rd_val, exp_q.pop_front());
  end

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic bit_io(input logic b, output logic seen);
    sda_m = b; qw(); scl = 1; qw(); seen = sda_line; qw(); scl = 0; qw();
  endtask

  task automatic do_start(); sda_m = 1; qw(); scl = 1; qw(); sda_m = 0; qw(); scl = 0; qw(); endtask
  task automatic do_stop(); sda_m = 0; qw(); scl = 1; qw(); sda_m = 1; qw(); qw(); endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    ack = ~s;
  endtask

  task automatic rd_byte(input logic mack);
    logic s;
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, s); v[i] = s; end
    bit_io(~mack, s);
    rd_val = v;
    ->rd_ev;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic a;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R1 pp_out", pp_out, 8'hFF);
    chk("R1 od_oe", od_oe, 8'h00);
    chk("R1 int_n", {7'd0, int_n}, 8'd1);
    chk("R1 sda_oe", {7'd0, sda_oe}, 8'd0);

    do_start(); wr_byte({PPA, 1'b0}, a); chk("R2 pp addr ack", {7'd0, a}, 8'd1);
    wr_byte(8'hA5, a); chk("R4 ack", {7'd0, a}, 8'd1); chk("R4 byte1", pp_out, 8'hA5);
    wr_byte(8'h3C, a); chk("R4 byte2", pp_out, 8'h3C);
    do_stop(); chk("R12 released", {7'd0, sda_oe}, 8'd0);

    do_start(); wr_byte({ODA, 1'b0}, a); chk("R2 od addr ack", {7'd0, a}, 8'd1);
    wr_byte(8'hF0, a); chk("R5 ack", {7'd0, a}, 8'd1); chk("R5 od_oe", od_oe, 8'h0F);
    do_stop(); chk("R9 no change no irq", {7'd0, int_n}, 8'd1);

    do_start(); wr_byte({PPA, 1'b1}, a); push(8'h3C, "R6 pp read"); rd_byte(1'b0); do_stop();

    od_in = 8'h81;
    do_start(); wr_byte({ODA, 1'b1}, a);
    od_in = 8'h42;
    push(8'h81, "R6 od read first"); rd_byte(1'b1);
    od_in = 8'h17;
    push(8'h42, "R7 resample byte2"); rd_byte(1'b1);
    push(8'h17, "R7 resample byte3"); rd_byte(1'b0);
    push(8'hFF, "R8 released after nack"); rd_byte(1'b0);
    do_stop();
    chk("R9 irq low", {7'd0, int_n}, 8'd0);

    do_start(); wr_byte({PPA, 1'b0}, a); wr_byte(8'h11, a); do_stop();
    chk("R10 pp write keeps irq", {7'd0, int_n}, 8'd0);
    chk("R4 pp 11", pp_out, 8'h11);
    do_start(); wr_byte({ODA, 1'b0}, a); wr_byte(8'hFF, a); do_stop();
    chk("R10 od write clears", {7'd0, int_n}, 8'd1);
    od_in = 8'h16;
    repeat (6) @(negedge clk);
    chk("R9 new change", {7'd0, int_n}, 8'd0);

    do_start(); wr_byte({7'h22, 1'b0}, a); chk("R3 no ack", {7'd0, a}, 8'd0);
    wr_byte(8'h00, a); chk("R3 data no ack", {7'd0, a}, 8'd0); do_stop();
    chk("R3 pp unchanged", pp_out, 8'h11);

    do_start(); wr_byte({7'h22, 1'b0}, a);
    do_start(); wr_byte({PPA, 1'b0}, a); chk("R11 ack after restart", {7'd0, a}, 8'd1);
    wr_byte(8'h99, a); chk("R11 pp", pp_out, 8'h99);
    do_start(); wr_byte({ODA, 1'b0}, a); wr_byte(8'h5A, a);
    chk("R11 od", od_oe, 8'hA5);
    do_stop();
    repeat (20) @(negedge clk);
    chk("R12 idle", {7'd0, sda_oe}, 8'd0);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard actual %0d left expected 0", exp_q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule